// File: doc/BRIEF.md
# Vector Interleave Permute Unit

This block carries out the two-source interleave permutes of a scalable vector datapath in one clocked stage. From two source vectors it builds one destination vector. The three operation families are zip, which interleaves matching elements from the low or the high half of both sources; unzip, which gathers the even-indexed or the odd-indexed elements of the two sources laid end to end; and transpose, which pairs the even or the odd element positions of the two sources. Elements are 8, 16, 32, 64 or 128 bits wide.

The active vector length is set for each operation as a number of 128-bit granules, up to a maximum fixed by a parameter. With 128-bit elements the element count can be odd. The unit then permutes only complete pairs and writes zero to the element left over. If fewer than two elements are active, or any encoding is invalid, the unit reports an undefined operation and gives no result. The result is computed in full before the output register is written, so a destination that shares storage with a source is safe.

Top module: `vec_interleave_unit`

## Requirements
- R1: Element-size codes are 0=8, 1=16, 2=32, 3=64 and 4=128 bits. Codes 5 to 7 give out_undef=1 and out_valid=0 one cycle later.
- R2: Opcodes 0 and 1 (zip low, zip high): with N active elements, P=floor(N/2) and h=0 for opcode 0 or h=1 for opcode 1, result[2i]=A[i+h*P] and result[2i+1]=B[i+h*P] for i<P.
- R3: Opcodes 2 and 3 (unzip even, unzip odd): let S be A[0..2P-1] followed by B[0..2P-1], and h=opcode bit 0. Then result[i]=S[2i+h] for i<2P.
- R4: Opcodes 4 and 6 (transpose even) and 5 and 7 (transpose odd), at every element size: result[2i]=A[2i+h] and result[2i+1]=B[2i+h] for i<P, with h=opcode bit 0.
- R5: When N is odd (128-bit elements with an odd granule count), result element N-1 is zero.
- R6: Result bits at and above vl_gran*128 are zero.
- R7: When N<2, the unit sets out_undef=1 and out_valid=0, and out_result is zero.
- R8: A granule count of 0, or one above MAXG, gives out_undef=1 and out_valid=0.
- R9: Each accepted input produces exactly one of out_valid or out_undef on the next clock. A cycle without in_valid produces neither on the next clock.
- R10: Synchronous active-high reset clears out_valid, out_undef and out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation code |
| esize | input | 3 | Element-size code |
| vl_gran | input | $clog2(MAXG+1) | Active length in 128-bit granules |
| src_a | input | MAXG*128 | First source vector |
| src_b | input | MAXG*128 | Second source vector |
| out_result | output | MAXG*128 | Registered permuted vector |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_undef | output | 1 | Undefined-operation flag, one clock after in_valid |

## Verification
The assertions assume that the control inputs are known while in_valid is high. They also assume that the granule count seen one cycle back is the one that belongs to the result now on the output. For this reason the stimulus changes inputs only on the falling clock edge and holds them steady across each rising edge. The sweep covers every opcode, every size code and every granule count that fits the port, including the invalid ones. Each operation is run with both fixed and random source data, and idle cycles are placed between operations so that the outputs must return to zero.

// File: rtl/vec_interleave_unit.sv
module vec_interleave_unit #(
  parameter int MAXG = 4,
  localparam int MAXW = MAXG * 128,
  localparam int VLW = $clog2(MAXG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [2:0]      esize,
  input  logic [VLW-1:0]  vl_gran,
  input  logic [MAXW-1:0] src_a,
  input  logic [MAXW-1:0] src_b,
  output logic [MAXW-1:0] out_result,
  output logic            out_valid,
  output logic            out_undef
);

  logic part, is_zip, is_uzp;
  logic size_ok, vl_ok, too_few, undef;
  logic [MAXW-1:0] perm_by [5];
  logic [MAXW-1:0] perm;

  assign part    = op[0];
  assign is_zip  = op[2:1] == 2'b00;
  assign is_uzp  = op[2:1] == 2'b01;
  assign size_ok = esize <= 3'd4;
  assign vl_ok   = (vl_gran != '0) && (int'(vl_gran) <= MAXG);
  assign too_few = (esize == 3'd4) && (vl_gran == VLW'(1));
  assign undef   = !size_ok || !vl_ok || too_few;

  for (genvar s = 0; s < 5; s++) begin : g_sz
    localparam int EW = 8 << s;
    localparam int L  = MAXW / EW;
    localparam int IW = $clog2(L);
    localparam int PG = 128 / EW;

    logic [EW-1:0] a_l [L];
    logic [EW-1:0] b_l [L];
    logic [MAXW-1:0] r;

    for (genvar j = 0; j < L; j++) begin : g_ln
      assign a_l[j] = src_a[j*EW +: EW];
      assign b_l[j] = src_b[j*EW +: EW];
    end

    always_comb begin
      int n, p, m, idx;
      logic hi;
      n = int'(vl_gran) * PG;
      p = n / 2;
      m = 2 * p;
      r = '0;
      for (int j = 0; j < L; j++) begin
        idx = 0;
        hi  = 1'b0;
        if (j < m) begin
          if (is_zip) begin
            idx = j / 2 + int'(part) * p;
            hi  = (j % 2) != 0;
          end else if (is_uzp) begin
            idx = 2 * j + int'(part);
            hi  = idx >= m;
            if (hi) idx = idx - m;
          end else begin
            idx = (j / 2) * 2 + int'(part);
            hi  = (j % 2) != 0;
          end
          r[j*EW +: EW] = hi ? b_l[IW'(idx)] : a_l[IW'(idx)];
        end
      end
    end

    assign perm_by[s] = r;
  end

  always_comb begin
    perm = '0;
    for (int s = 0; s < 5; s++)
      if (int'(esize) == s) perm = perm_by[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_undef  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= in_valid && !undef;
      out_undef <= in_valid && undef;
      if (in_valid) out_result <= undef ? '0 : perm;
    end
  end

endmodule

// File: rtl/vec_interleave_unit_chk.sv
module vec_interleave_unit_chk #(
  parameter int MAXG = 4,
  localparam int MAXW = MAXG * 128,
  localparam int VLW = $clog2(MAXG + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic [2:0]      esize,
  input logic [VLW-1:0]  vl_gran,
  input logic [MAXW-1:0] out_result,
  input logic            out_valid,
  input logic            out_undef
);

  p_bad_size_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esize > 3'd4) |=> (out_undef && !out_valid));

  p_tail_odd_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(esize) == 3'd4 && $past(vl_gran[0]))
      |-> ((out_result >> ((int'($past(vl_gran)) - 1) * 128)) == '0));

  p_beyond_vl_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_result >> (int'($past(vl_gran)) * 128)) == '0));

  p_few_elems_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && esize == 3'd4 && vl_gran == VLW'(1)) |=> (out_undef && !out_valid));

  p_undef_zero_r7: assert property (@(posedge clk) disable iff (rst)
    out_undef |-> (out_result == '0));

  p_bad_len_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (vl_gran == '0 || int'(vl_gran) > MAXG)) |=> out_undef);

  p_one_reply_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_valid ^ out_undef));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_undef));

endmodule

bind vec_interleave_unit vec_interleave_unit_chk #(.MAXG(MAXG)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .esize(esize), .vl_gran(vl_gran),
  .out_result(out_result), .out_valid(out_valid), .out_undef(out_undef)
);

// File: tb/test_vec_interleave_unit.sv
`timescale 1ns/1ps
module test_vec_interleave_unit;
  localparam int MAXG = 4;
  localparam int MW = MAXG * 128;
  localparam int VLW = $clog2(MAXG + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [2:0] esize = '0;
  logic [VLW-1:0] vl_gran = '0;
  logic [MW-1:0] src_a = '0;
  logic [MW-1:0] src_b = '0;
  logic [MW-1:0] out_result;
  logic out_valid, out_undef;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  vec_interleave_unit #(.MAXG(MAXG)) i_vec_interleave_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .esize(esize),
    .vl_gran(vl_gran), .src_a(src_a), .src_b(src_b),
    .out_result(out_result), .out_valid(out_valid), .out_undef(out_undef)
  );

  task automatic check(input string req, input string what,
                       input logic [MW-1:0] act, input logic [MW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [MW-1:0] model(input int o, input int es, input int vl,
                                          input logic [MW-1:0] a, input logic [MW-1:0] b);
    int ew, n, p, m, h, k;
    logic hi;
    logic [MW-1:0] msk, r;
    ew = 8 << es;
    n = vl * 128 / ew;
    p = n / 2;
    m = 2 * p;
    h = o % 2;
    msk = {MW{1'b1}} >> (MW - ew);
    r = '0;
    for (int j = 0; j < m; j++) begin
      if (o < 2) begin
        k = j / 2 + h * p; hi = (j % 2) == 1;
      end else if (o < 4) begin
        k = 2 * j + h; hi = k >= m;
        if (hi) k = k - m;
      end else begin
        k = j - (j % 2) + h; hi = (j % 2) == 1;
      end
      r = r | ((((hi ? b : a) >> (k * ew)) & msk) << (j * ew));
    end
    return r;
  endfunction

  function automatic logic [MW-1:0] rand_vec();
    logic [MW-1:0] v;
    for (int i = 0; i < MW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R10", "valid after reset", MW'(out_valid), '0);
    check("R10", "undef after reset", MW'(out_undef), '0);
    check("R10", "result after reset", out_result, '0);
    rst = 1'b0;
    for (int pat = 0; pat < 2; pat++)
      for (int es = 0; es < 8; es++)
        for (int vl = 0; vl < (1 << VLW); vl++)
          for (int o = 0; o < 8; o++) begin
            logic bad;
            int n;
            string tag;
            if (pat == 0)
              for (int i = 0; i < MW / 8; i++) begin
                src_a[i*8 +: 8] = 8'(i);
                src_b[i*8 +: 8] = 8'(8'h80 + i);
              end
            else begin
              src_a = rand_vec();
              src_b = rand_vec();
            end
            op = 3'(o); esize = 3'(es); vl_gran = VLW'(vl); in_valid = 1'b1;
            n = (es <= 4) ? vl * 128 / (8 << es) : 0;
            bad = (es > 4) || (vl == 0) || (vl > MAXG) || (n < 2);
            if (es > 4) tag = "R1";
            else if (vl == 0 || vl > MAXG) tag = "R8";
            else if (n < 2) tag = "R7";
            else if ((n % 2) == 1) tag = "R5";
            else if (o < 2) tag = "R2";
            else if (o < 4) tag = "R3";
            else tag = "R4";
            @(negedge clk);
            in_valid = 1'b0;
            check("R9", "valid", MW'(out_valid), MW'(!bad));
            check(bad ? tag : "R9", "undef", MW'(out_undef), MW'(bad));
            check(tag, "result", out_result, bad ? '0 : model(o, es, vl, src_a, src_b));
            if (!bad) check("R6", "beyond length", out_result >> (vl * 128), '0);
            if (o == 7) begin
              @(negedge clk);
              check("R9", "idle valid", MW'(out_valid), '0);
              check("R9", "idle undef", MW'(out_undef), '0);
            end
          end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule